// File: doc/BRIEF.md
# Accumulator ALU with Scaling Shifters

This block is the arithmetic core of a fixed-point signal-processing datapath, built around one 32-bit accumulator. Every arithmetic or logical operation takes the accumulator as its first operand and writes its result back into it. The second operand is either a 32-bit product word or a 16-bit data word. The data word first passes through a scaler that shifts it left by a programmed amount, with optional sign extension.

Reading the accumulator back to memory uses a separate output path. One 16-bit half of the accumulator is selected and shifted left before it leaves the block, and the accumulator itself is not changed. Two further operations complete the set. A normalize step shifts out redundant sign bits one at a time and counts them. A bit test copies one chosen bit of a data word into a flag. A small opcode input stands in for the surrounding instruction decoder.

Top module: `acc_alu_core`

## Requirements
- R1: The opcode input is decoded as 0 no-op, 1 add, 2 subtract, 3 load, 4 AND, 5 OR, 6 XOR, 7 normalize and 8 bit test. A load writes the second operand into the accumulator on the next rising edge. When `src_sel_i` is 1 the second operand is `prod_i`; when it is 0 it is the scaler output.
- R2: The scaler shifts the 16-bit data word left by `shift_i` places and fills the vacated low bits with zeros. Shift amounts from 17 to 31 behave as 16.
- R3: When `sxm_i` is 1, the scaler fills the bits above the data word with copies of its bit 15. When `sxm_i` is 0, it fills them with zeros.
- R4: Add sets the accumulator to the 32-bit sum modulo 2^32 of the accumulator and the second operand. The carry flag takes the unsigned carry out of bit 31.
- R5: Subtract sets the accumulator to the accumulator minus the second operand, modulo 2^32. The carry flag is 1 when no borrow occurs, that is, when the accumulator is at least the operand as unsigned numbers.
- R6: The overflow flag is 1 when the latest add or subtract overflowed as a signed 32-bit operation, and 0 otherwise. Both carry and overflow hold their values through every other opcode.
- R7: AND, OR and XOR combine the low 16 bits of the accumulator with the low 16 bits of the second operand. The upper 16 bits of the result are zero.
- R8: The store output is combinational. It shows the accumulator shifted left by `st_shift_i` (0 to 7) places, taking the upper half when `st_hi_i` is 1 and the lower half when it is 0. Bits entering the upper half come from the accumulator bits below it; bits entering the lower half are zero. Reading the store output never changes the accumulator.
- R9: Normalize acts only when accumulator bits 31 and 30 are equal and the accumulator is nonzero. In that case it shifts the accumulator left by one, adds one modulo 16 to the 4-bit count and clears the done flag. In every other case it sets the done flag and leaves the accumulator and the count unchanged.
- R10: A load clears the normalize count and the done flag.
- R11: Bit test sets the test flag to bit `bit_sel_i` of `data_i`, where index 0 is the least significant bit. Every other opcode holds the test flag.
- R12: After reset, the accumulator, carry, overflow, test flag, normalize count and done flag are all zero.
- R13: A no-op, and any opcode from 9 to 15, leaves the accumulator and every flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Opcode for this cycle |
| src_sel_i | input | 1 | Second-operand select: 1 product, 0 scaler |
| data_i | input | 16 | Data-bus word for the scaler and the bit test |
| shift_i | input | 5 | Scaler left-shift amount |
| sxm_i | input | 1 | Sign-extension mode for the scaler |
| prod_i | input | 32 | Product word from the multiplier |
| bit_sel_i | input | 4 | Bit index used by the bit test |
| st_hi_i | input | 1 | Store half select: 1 upper, 0 lower |
| st_shift_i | input | 3 | Store output left-shift amount |
| st_data_o | output | 16 | Shifted accumulator half for storing |
| acc_o | output | 32 | Accumulator contents |
| carry_o | output | 1 | Carry flag |
| ovf_o | output | 1 | Signed overflow flag |
| tc_o | output | 1 | Bit-test flag |
| norm_cnt_o | output | 4 | Normalize shift count |
| norm_done_o | output | 1 | Normalize finished flag |

## Verification
The clocked properties assume that the opcode, select, data and product inputs are known and settled at every rising edge after reset, and that the opcode is taken as a raw 4-bit code. The combinational checks in the shifters assume known inputs and skip any evaluation with unknown values. The bench keeps within these assumptions by driving every input on the falling edge from a fully defined state and returning the opcode to no-op between operations. It also drives out-of-range shift amounts and undefined opcodes on purpose, so the clamping and ignore rules are exercised inside the assumed input space.

// File: rtl/acc_alu_pkg.sv
`timescale 1ns/1ps
package acc_alu_pkg;

   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_NOP   = 4'd0,
      OP_ADD   = 4'd1,
      OP_SUB   = 4'd2,
      OP_LOAD  = 4'd3,
      OP_AND   = 4'd4,
      OP_OR    = 4'd5,
      OP_XOR   = 4'd6,
      OP_NORM  = 4'd7,
      OP_BTST  = 4'd8
   } alu_op_e;

   function automatic logic is_arith(input logic [OP_W-1:0] code);
      return (code == OP_ADD) || (code == OP_SUB);
   endfunction

   function automatic logic is_defined(input logic [OP_W-1:0] code);
      return code <= OP_BTST;
   endfunction

endpackage

// File: rtl/acc_in_scaler.sv
`timescale 1ns/1ps
module acc_in_scaler #(
   parameter int DATA_W    = 16,
   parameter int SCALE_MAX = 16,
   parameter bit BARREL    = 1'b1,
   localparam int ACC_W    = 2 * DATA_W,
   localparam int SHW      = $clog2(ACC_W)
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic [SHW-1:0]    shift_i,
   input  logic              sxm_i,
   output logic [ACC_W-1:0]  scaled_o
);

   logic [SHW-1:0]   amt;
   logic [ACC_W-1:0] ext;

   assign amt = (int'(shift_i) > SCALE_MAX) ? SHW'(SCALE_MAX) : shift_i;
   assign ext = sxm_i ? {{DATA_W{data_i[DATA_W-1]}}, data_i}
                      : {{DATA_W{1'b0}}, data_i};

   if (BARREL) begin : g_barrel
      logic [ACC_W-1:0] stage [0:SHW];
      assign stage[0] = ext;
      for (genvar i = 0; i < SHW; i++) begin : g_stage
         assign stage[i+1] = amt[i] ? (stage[i] << (1 << i)) : stage[i];
      end
      assign scaled_o = stage[SHW];
   end else begin : g_direct
      assign scaled_o = ext << amt;
   end

   always_comb begin
      if (!$isunknown({data_i, shift_i, sxm_i})) begin
         a_r2_low_zero: assert ((scaled_o & ~({ACC_W{1'b1}} << amt)) == '0)
            else $error("scaler low fill not zero");
         if (SCALE_MAX == DATA_W) begin
            a_r3_top_bit: assert (scaled_o[ACC_W-1] ==
                  ((sxm_i || int'(amt) == SCALE_MAX) ? data_i[DATA_W-1] : 1'b0))
               else $error("scaler top bit fill wrong");
         end
      end
   end

endmodule

// File: rtl/acc_alu_unit.sv
`timescale 1ns/1ps
module acc_alu_unit
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 16,
   localparam int ACC_W = 2 * DATA_W
) (
   input  alu_op_e          op_i,
   input  logic [ACC_W-1:0] a_i,
   input  logic [ACC_W-1:0] b_i,
   output logic [ACC_W-1:0] res_o,
   output logic             wr_o,
   output logic             flag_wr_o,
   output logic             carry_o,
   output logic             ovf_o
);

   logic [ACC_W:0]  sum_x;
   logic [ACC_W:0]  dif_x;
   logic [DATA_W-1:0] lo_a, lo_b;

   assign sum_x = {1'b0, a_i} + {1'b0, b_i};
   assign dif_x = {1'b0, a_i} + {1'b0, ~b_i} + {{ACC_W{1'b0}}, 1'b1};
   assign lo_a  = a_i[DATA_W-1:0];
   assign lo_b  = b_i[DATA_W-1:0];

   always_comb begin
      res_o     = a_i;
      wr_o      = 1'b0;
      flag_wr_o = 1'b0;
      carry_o   = 1'b0;
      ovf_o     = 1'b0;
      unique case (op_i)
         OP_ADD: begin
            res_o     = sum_x[ACC_W-1:0];
            wr_o      = 1'b1;
            flag_wr_o = 1'b1;
            carry_o   = sum_x[ACC_W];
            ovf_o     = (a_i[ACC_W-1] == b_i[ACC_W-1]) &&
                        (sum_x[ACC_W-1] != a_i[ACC_W-1]);
         end
         OP_SUB: begin
            res_o     = dif_x[ACC_W-1:0];
            wr_o      = 1'b1;
            flag_wr_o = 1'b1;
            carry_o   = dif_x[ACC_W];
            ovf_o     = (a_i[ACC_W-1] != b_i[ACC_W-1]) &&
                        (dif_x[ACC_W-1] != a_i[ACC_W-1]);
         end
         OP_LOAD: begin
            res_o = b_i;
            wr_o  = 1'b1;
         end
         OP_AND: begin
            res_o = {{DATA_W{1'b0}}, lo_a & lo_b};
            wr_o  = 1'b1;
         end
         OP_OR: begin
            res_o = {{DATA_W{1'b0}}, lo_a | lo_b};
            wr_o  = 1'b1;
         end
         OP_XOR: begin
            res_o = {{DATA_W{1'b0}}, lo_a ^ lo_b};
            wr_o  = 1'b1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/acc_store_shifter.sv
`timescale 1ns/1ps
module acc_store_shifter #(
   parameter int DATA_W          = 16,
   parameter int STORE_SHIFT_MAX = 7,
   localparam int ACC_W          = 2 * DATA_W,
   localparam int STW            = $clog2(STORE_SHIFT_MAX + 1)
) (
   input  logic [ACC_W-1:0]  acc_i,
   input  logic              hi_i,
   input  logic [STW-1:0]    shift_i,
   output logic [DATA_W-1:0] data_o
);

   logic [ACC_W-1:0] wide;

   assign wide   = acc_i << shift_i;
   assign data_o = hi_i ? wide[ACC_W-1:DATA_W] : wide[DATA_W-1:0];

   always_comb begin
      if (!$isunknown({acc_i, hi_i, shift_i}) && !hi_i) begin
         a_r8_low_half_fill: assert ((data_o & ~({DATA_W{1'b1}} << shift_i)) == '0)
            else $error("store low half fill not zero");
      end
   end

endmodule

// File: rtl/acc_alu_core.sv
`timescale 1ns/1ps
module acc_alu_core
   import acc_alu_pkg::*;
#(
   parameter int DATA_W          = 16,
   parameter int SCALE_MAX       = 16,
   parameter int STORE_SHIFT_MAX = 7,
   parameter int NORM_CNT_W      = 4,
   parameter bit SCALER_BARREL   = 1'b1,
   localparam int ACC_W          = 2 * DATA_W,
   localparam int SHW            = $clog2(ACC_W),
   localparam int BSW            = $clog2(DATA_W),
   localparam int STW            = $clog2(STORE_SHIFT_MAX + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [OP_W-1:0]       op_i,
   input  logic                  src_sel_i,
   input  logic [DATA_W-1:0]     data_i,
   input  logic [SHW-1:0]        shift_i,
   input  logic                  sxm_i,
   input  logic [ACC_W-1:0]      prod_i,
   input  logic [BSW-1:0]        bit_sel_i,
   input  logic                  st_hi_i,
   input  logic [STW-1:0]        st_shift_i,
   output logic [DATA_W-1:0]     st_data_o,
   output logic [ACC_W-1:0]      acc_o,
   output logic                  carry_o,
   output logic                  ovf_o,
   output logic                  tc_o,
   output logic [NORM_CNT_W-1:0] norm_cnt_o,
   output logic                  norm_done_o
);

   if (DATA_W < 4) begin : g_chk_width
      $error("DATA_W must be at least 4");
   end
   if (SCALE_MAX > DATA_W || SCALE_MAX < 0) begin : g_chk_scale
      $error("SCALE_MAX must lie in 0..DATA_W");
   end
   if (STORE_SHIFT_MAX >= DATA_W || STORE_SHIFT_MAX < 1) begin : g_chk_store
      $error("STORE_SHIFT_MAX must lie in 1..DATA_W-1");
   end
   if (NORM_CNT_W < 1) begin : g_chk_cnt
      $error("NORM_CNT_W must be positive");
   end

   alu_op_e               op;
   logic [ACC_W-1:0]      acc_q;
   logic [ACC_W-1:0]      scaled;
   logic [ACC_W-1:0]      opnd_b;
   logic [ACC_W-1:0]      alu_res;
   logic                  alu_wr, flag_wr, alu_c, alu_v;
   logic                  carry_q, ovf_q, tc_q, done_q;
   logic [NORM_CNT_W-1:0] cnt_q;
   logic                  norm_go;

   assign op = alu_op_e'(op_i);

   acc_in_scaler #(
      .DATA_W    (DATA_W),
      .SCALE_MAX (SCALE_MAX),
      .BARREL    (SCALER_BARREL)
   ) scaler_i (
      .data_i   (data_i),
      .shift_i  (shift_i),
      .sxm_i    (sxm_i),
      .scaled_o (scaled)
   );

   assign opnd_b = src_sel_i ? prod_i : scaled;

   acc_alu_unit #(
      .DATA_W (DATA_W)
   ) alu_i (
      .op_i      (op),
      .a_i       (acc_q),
      .b_i       (opnd_b),
      .res_o     (alu_res),
      .wr_o      (alu_wr),
      .flag_wr_o (flag_wr),
      .carry_o   (alu_c),
      .ovf_o     (alu_v)
   );

   assign norm_go = (acc_q[ACC_W-1] == acc_q[ACC_W-2]) && (|acc_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         carry_q <= 1'b0;
         ovf_q   <= 1'b0;
         tc_q    <= 1'b0;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         if (op == OP_NORM) begin
            if (norm_go) begin
               acc_q  <= {acc_q[ACC_W-2:0], 1'b0};
               cnt_q  <= cnt_q + 1'b1;
               done_q <= 1'b0;
            end else begin
               done_q <= 1'b1;
            end
         end
         if (op == OP_BTST) begin
            tc_q <= data_i[bit_sel_i];
         end
         if (alu_wr) begin
            acc_q <= alu_res;
         end
         if (flag_wr) begin
            carry_q <= alu_c;
            ovf_q   <= alu_v;
         end
         if (op == OP_LOAD) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
         end
      end
   end

   acc_store_shifter #(
      .DATA_W          (DATA_W),
      .STORE_SHIFT_MAX (STORE_SHIFT_MAX)
   ) store_i (
      .acc_i   (acc_q),
      .hi_i    (st_hi_i),
      .shift_i (st_shift_i),
      .data_o  (st_data_o)
   );

   assign acc_o       = acc_q;
   assign carry_o     = carry_q;
   assign ovf_o       = ovf_q;
   assign tc_o        = tc_q;
   assign norm_cnt_o  = cnt_q;
   assign norm_done_o = done_q;

   a_r1_load_product: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_LOAD && src_sel_i) |=> (acc_o == $past(prod_i)))
      else $error("load of product not seen in accumulator");

   a_r6_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !is_arith(op_i) |=> ($stable(carry_o) && $stable(ovf_o)))
      else $error("carry or overflow changed outside add or subtract");

   a_r9_norm_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_NORM && acc_o[ACC_W-1] != acc_o[ACC_W-2])
      |=> (norm_done_o && $stable(acc_o) && $stable(norm_cnt_o)))
      else $error("normalize did not stop on a normalized value");

   a_r10_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_LOAD) |=> (norm_cnt_o == '0 && !norm_done_o))
      else $error("load did not clear normalize state");

   a_r11_bit_test: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_BTST) |=> (tc_o == $past(data_i[bit_sel_i])))
      else $error("bit test flag mismatch");

   a_r13_undef_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !is_defined(op_i) |=> ($stable(acc_o) && $stable(tc_o) && $stable(norm_cnt_o)))
      else $error("undefined opcode changed state");

endmodule

// File: tb/acc_alu_core_tb.sv
`timescale 1ns/1ps
module acc_alu_core_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op_i = '0;
   logic        src_sel_i = 1'b0;
   logic [15:0] data_i = '0;
   logic [4:0]  shift_i = '0;
   logic        sxm_i = 1'b0;
   logic [31:0] prod_i = '0;
   logic [3:0]  bit_sel_i = '0;
   logic        st_hi_i = 1'b0;
   logic [2:0]  st_shift_i = '0;
   logic [15:0] st_data_o;
   logic [31:0] acc_o;
   logic        carry_o, ovf_o, tc_o, norm_done_o;
   logic [3:0]  norm_cnt_o;

   int n_chk = 0;
   int n_bad = 0;

   logic [31:0] m_acc = '0;
   logic        m_c = 1'b0, m_v = 1'b0, m_tc = 1'b0, m_done = 1'b0;
   logic [3:0]  m_cnt = '0;

   always #2.5 clk = ~clk;

   acc_alu_core dut_i (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .src_sel_i(src_sel_i),
      .data_i(data_i), .shift_i(shift_i), .sxm_i(sxm_i), .prod_i(prod_i),
      .bit_sel_i(bit_sel_i), .st_hi_i(st_hi_i), .st_shift_i(st_shift_i),
      .st_data_o(st_data_o), .acc_o(acc_o), .carry_o(carry_o), .ovf_o(ovf_o),
      .tc_o(tc_o), .norm_cnt_o(norm_cnt_o), .norm_done_o(norm_done_o)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] scale_ref(input logic [15:0] d, input int s, input logic sx);
      longint v;
      int a;
      a = (s > 16) ? 16 : s;
      v = sx ? longint'($signed(d)) : longint'(d);
      v = v * (longint'(1) << a);
      return v[31:0];
   endfunction

   task automatic check_all(input string req);
      chk(req, "acc", acc_o, m_acc);
      chk(req, "carry", {31'd0, carry_o}, {31'd0, m_c});
      chk(req, "ovf", {31'd0, ovf_o}, {31'd0, m_v});
      chk(req, "tc", {31'd0, tc_o}, {31'd0, m_tc});
      chk(req, "cnt", {28'd0, norm_cnt_o}, {28'd0, m_cnt});
      chk(req, "done", {31'd0, norm_done_o}, {31'd0, m_done});
   endtask

   task automatic run_op(input string req, input logic [3:0] op, input logic src,
                         input logic [15:0] d, input int sh, input logic sx,
                         input logic [31:0] p, input logic [3:0] bs);
      logic [31:0] b;
      longint ss;
      @(negedge clk);
      op_i = op; src_sel_i = src; data_i = d; shift_i = 5'(sh); sxm_i = sx;
      prod_i = p; bit_sel_i = bs;
      b = src ? p : scale_ref(d, sh, sx);
      case (op)
         4'd1: begin
            ss = longint'({1'b0, m_acc}) + longint'({1'b0, b});
            m_c = ss[32];
            ss = longint'($signed(m_acc)) + longint'($signed(b));
            m_v = (ss > 64'sh7FFFFFFF) || (ss < -64'sh80000000);
            m_acc = m_acc + b;
         end
         4'd2: begin
            m_c = (m_acc >= b);
            ss = longint'($signed(m_acc)) - longint'($signed(b));
            m_v = (ss > 64'sh7FFFFFFF) || (ss < -64'sh80000000);
            m_acc = m_acc - b;
         end
         4'd3: begin m_acc = b; m_cnt = '0; m_done = 1'b0; end
         4'd4: m_acc = {16'd0, m_acc[15:0] & b[15:0]};
         4'd5: m_acc = {16'd0, m_acc[15:0] | b[15:0]};
         4'd6: m_acc = {16'd0, m_acc[15:0] ^ b[15:0]};
         4'd7: begin
            if (m_acc[31] == m_acc[30] && m_acc != 0) begin
               m_acc = m_acc * 2; m_cnt = m_cnt + 4'd1; m_done = 1'b0;
            end else m_done = 1'b1;
         end
         4'd8: m_tc = d[bs];
         default: ;
      endcase
      @(posedge clk);
      #1;
      op_i = 4'd0;
      check_all(req);
   endtask

   task automatic load_p(input logic [31:0] p);
      run_op("R1", 4'd3, 1'b1, 16'h0, 0, 1'b0, p, 4'd0);
   endtask

   initial begin
      logic [15:0] dpat [6];
      logic [31:0] vpat [6];
      dpat = '{16'h0001, 16'h8000, 16'h7FFF, 16'hFFFF, 16'hA5C3, 16'h1234};
      vpat = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF, 32'h12345678};
      repeat (3) @(posedge clk);
      #1;
      check_all("R12");
      chk("R12", "store", {16'd0, st_data_o}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // scaler sweep, R2 and R3
      foreach (dpat[i]) begin
         for (int sx = 0; sx < 2; sx++) begin
            for (int s = 0; s <= 16; s++) begin
               run_op(sx ? "R3" : "R2", 4'd3, 1'b0, dpat[i], s, 1'(sx), 32'hDEAD0000, 4'd0);
            end
            run_op("R2", 4'd3, 1'b0, dpat[i], 17, 1'(sx), 32'h0, 4'd0);
            run_op("R2", 4'd3, 1'b0, dpat[i], 31, 1'(sx), 32'h0, 4'd0);
         end
      end

      // add and subtract over corner values, R4 R5 R6
      foreach (vpat[i]) begin
         foreach (vpat[j]) begin
            load_p(vpat[i]);
            run_op("R4", 4'd1, 1'b1, 16'h0, 0, 1'b0, vpat[j], 4'd0);
            load_p(vpat[i]);
            run_op("R5", 4'd2, 1'b1, 16'h0, 0, 1'b0, vpat[j], 4'd0);
            run_op("R6", 4'd5, 1'b1, 16'h0, 0, 1'b0, 32'h0, 4'd0);
         end
      end
      load_p(32'h7FFF0000);
      run_op("R4", 4'd1, 1'b0, 16'h8001, 4, 1'b1, 32'h0, 4'd0);
      run_op("R5", 4'd2, 1'b0, 16'hFFFF, 16, 1'b0, 32'h0, 4'd0);

      // logic operations, R7
      foreach (dpat[i]) begin
         load_p(32'hDEADBEEF);
         run_op("R7", 4'd4, 1'b0, dpat[i], 0, 1'b1, 32'h0, 4'd0);
         load_p(32'hDEADBEEF);
         run_op("R7", 4'd5, 1'b0, dpat[i], 0, 1'b1, 32'h0, 4'd0);
         load_p(32'hDEADBEEF);
         run_op("R7", 4'd6, 1'b1, 16'h0, 0, 1'b0, {dpat[i], dpat[i]}, 4'd0);
      end

      // store output, R8
      load_p(32'h89ABCDEF);
      for (int h = 0; h < 2; h++) begin
         for (int s = 0; s < 8; s++) begin
            logic [31:0] w;
            @(negedge clk);
            st_hi_i = 1'(h); st_shift_i = 3'(s);
            #1;
            w = m_acc << s;
            chk("R8", "store", {16'd0, st_data_o}, {16'd0, h ? w[31:16] : w[15:0]});
         end
      end
      run_op("R8", 4'd0, 1'b1, 16'hFFFF, 3, 1'b1, 32'h5555AAAA, 4'd0);

      // normalize, R9 R10
      load_p(32'h00000001);
      for (int k = 0; k < 32; k++) run_op("R9", 4'd7, 1'b0, 16'h0, 0, 1'b0, 32'h0, 4'd0);
      chk("R9", "cnt wrap", {28'd0, norm_cnt_o}, 32'd14);
      load_p(32'hFFFFFFFF);
      chk("R10", "cnt clear", {28'd0, norm_cnt_o}, 32'd0);
      for (int k = 0; k < 33; k++) run_op("R9", 4'd7, 1'b0, 16'h0, 0, 1'b0, 32'h0, 4'd0);
      load_p(32'h0);
      run_op("R9", 4'd7, 1'b0, 16'h0, 0, 1'b0, 32'h0, 4'd0);
      chk("R9", "zero done", {31'd0, norm_done_o}, 32'd1);
      load_p(32'h00004000);
      run_op("R10", 4'd7, 1'b0, 16'h0, 0, 1'b0, 32'h0, 4'd0);

      // bit test, R11
      for (int b = 0; b < 16; b++) begin
         run_op("R11", 4'd8, 1'b0, 16'hA5C3, 0, 1'b0, 32'h0, 4'(b));
         run_op("R11", 4'd1, 1'b0, 16'h0003, 0, 1'b0, 32'h0, 4'(b));
      end

      // undefined opcodes, R13
      load_p(32'hC0FFEE11);
      run_op("R13", 4'd8, 1'b0, 16'h8000, 0, 1'b0, 32'h0, 4'd15);
      for (int o = 9; o < 16; o++) begin
         run_op("R13", 4'(o), 1'b1, 16'hFFFF, 5, 1'b1, 32'h12345678, 4'd0);
      end
      run_op("R13", 4'd0, 1'b1, 16'hFFFF, 5, 1'b1, 32'h12345678, 4'd0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule